// File: doc/BRIEF.md
# Multi-CPU Interrupt Distributor

This block collects interrupt requests and hands each of four processors the most urgent request that it may take. IDs 0 to 31 belong to each processor on its own. Every processor has its own enable and pending bits for these IDs, and software raises them, either through the pending-set bank or through the software-interrupt register. IDs 32 and up are shared lines, driven on `shared_irq`, where bit i carries ID 32+i. Each shared line can be routed to any set of processors.

Software sets the block up over a 32-bit register port. The port has a write strobe, a read strobe, a byte address, write data, and the number of the processor making the access. That number selects which banked copy of IDs 0 to 31 the access reaches. For each processor, the block computes combinationally a request flag, the ID of the winning interrupt and that interrupt's priority.

Top module: `irqd_top`

## Requirements
- R1: After reset, the control bit, all enables, all pending bits, all priority bytes and all target bytes are 0. Every `cpu_irq` output is low.
- R2: The word at 0x004 reads back NUM_IRQ/32-1 in bits [4:0]. This is 1 for the default of 64 IDs.
- R3: Enables are packed 32 IDs per word, with word w holding IDs 32w to 32w+31. A 1 written to 0x100+4w sets the matching enable, and a 1 written to 0x180+4w clears it. A 0 bit leaves the enable unchanged. Either address reads the current enables.
- R4: Bit 0 of the control word at 0x000 gates forwarding. While this bit is 0, every `cpu_irq` stays low.
- R5: Priorities are one byte per ID, four per word, at 0x400+4·(id/4), in byte lane id mod 4. Of the candidates, the one with the numerically lowest priority wins.
- R6: When two candidates have equal priority, the lower ID wins.
- R7: Targets are one byte per shared ID at 0x800+4·(id/4), in byte lane id mod 4. Bit n of the byte routes the ID to processor n.
- R8: For IDs 0 to 31, an enable or pending access reaches only the copy of the processor named on `bus_cpu`. Another processor's copy is untouched.
- R9: A write to 0xF00 sets pending for ID wdata[3:0] in the banked copy of every processor n whose bit wdata[16+n] is 1.
- R10: Trigger mode is 2 bits per ID, 16 IDs per word, at 0xC00+4·(id/16), in bits [2·(id mod 16)+1 : 2·(id mod 16)]. When bit 1 of the field is 0, the line is level-sensitive and is pending while it is high. When bit 1 is 1, a rising edge latches pending, which holds until a 1 is written to 0x280+4w. Pending reads at 0x200+4w and 0x280+4w.
- R11: Trigger-mode fields read back as written.
- R12: Read data appears on `rdata` in the cycle after `rd_en`. In a cycle that follows no read, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cpu | input | 2 | Number of the processor making the register access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after rd_en |
| shared_irq | input | NUM_IRQ-32 | Shared interrupt lines, bit i is ID 32+i |
| cpu_irq | output | NUM_CPU | Request flag per processor |
| cpu_irq_id | output | NUM_CPU·6 | Winning ID per processor, 6 bits each |
| cpu_irq_prio | output | NUM_CPU·8 | Winning priority per processor |

## Verification
Selection is exercised in several ways. Priorities are distinct first, and then a tie is made, so strict ordering is checked separately from the ID tie-break. Shared lines are raised toward processors whose target bits differ, which shows whether routing follows the target byte. One line is set to edge mode and pulsed for a single cycle. It must stay pending once the pulse has ended, and a level line must drop out as soon as it goes low. Enables and soft interrupts are applied from different processors, and the other processors' outputs and banked readback are checked. This exposes any sharing of the private copies.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  // fixed register map, byte addresses
  localparam logic [11:0] A_CTRL = 12'h000;
  localparam logic [11:0] A_INFO = 12'h004;
  localparam logic [11:0] A_SGI  = 12'hF00;
  localparam logic [3:0]  R_EN   = 4'h1;   // addr[11:8]; addr[7]=0 set, 1 clear
  localparam logic [3:0]  R_PEND = 4'h2;   // addr[11:8]; addr[7]=0 set, 1 clear
  localparam logic [3:0]  R_CFG  = 4'hC;   // addr[11:8]
  localparam logic [1:0]  R_PRIO = 2'b01;  // addr[11:10]
  localparam logic [1:0]  R_TGT  = 2'b10;  // addr[11:10]
endpackage

// File: rtl/irqd_regs.sv
module irqd_regs
  import irqd_pkg::*;
#(
  parameter int NIRQ = 64,
  parameter int NCPU = 4,
  parameter int PW   = 8,
  parameter int CW   = 2,
  localparam int NSH = NIRQ - 32,
  localparam int NW  = NIRQ / 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [CW-1:0]              bus_cpu,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [11:0]                addr,
  input  logic [31:0]                wdata,
  input  logic [NSH-1:0]             shared_irq,
  output logic [31:0]                rdata,
  output logic                       fwd_en,
  output logic [NCPU-1:0][31:0]      en_pv,
  output logic [NCPU-1:0][31:0]      pend_pv,
  output logic [NSH-1:0]             en_sh,
  output logic [NSH-1:0]             pend_sh_eff,
  output logic [NSH-1:0][NCPU-1:0]   tgt,
  output logic [NIRQ-1:0][PW-1:0]    prio
);
  logic                     ctrl_q, ctrl_d;
  logic [NCPU-1:0][31:0]    en_pv_q, en_pv_d, pend_pv_q, pend_pv_d;
  logic [NSH-1:0]           en_sh_q, en_sh_d, pend_sh_q, pend_sh_d, line_q;
  logic [NSH-1:0][NCPU-1:0] tgt_q, tgt_d;
  logic [NIRQ-1:0][PW-1:0]  prio_q, prio_d;
  logic [NIRQ-1:0][1:0]     cfg_q, cfg_d;
  logic [31:0]              rdata_q, rdata_d;

  // decoded indices
  int bw, lw, cw;
  assign bw = int'(addr[6:2]);   // bit-bank word
  assign lw = int'(addr[9:2]);   // byte-lane word
  assign cw = int'(addr[7:2]);   // trigger-mode word

  always_comb begin
    for (int i = 0; i < NSH; i++)
      pend_sh_eff[i] = pend_sh_q[i] | (!cfg_q[32+i][1] & shared_irq[i]);
  end

  // next state
  always_comb begin
    ctrl_d = ctrl_q; en_pv_d = en_pv_q; en_sh_d = en_sh_q;
    pend_pv_d = pend_pv_q; pend_sh_d = pend_sh_q;
    prio_d = prio_q; tgt_d = tgt_q; cfg_d = cfg_q;
    if (wr_en) begin
      if (addr == A_CTRL) ctrl_d = wdata[0];
      if (addr[11:8] == R_EN && bw < NW) begin
        for (int b = 0; b < 32; b++) if (wdata[b]) begin
          if (bw == 0) en_pv_d[bus_cpu][b] = !addr[7];
          else         en_sh_d[(bw-1)*32+b] = !addr[7];
        end
      end
      if (addr[11:8] == R_PEND && bw < NW) begin
        for (int b = 0; b < 32; b++) if (wdata[b]) begin
          if (bw == 0) pend_pv_d[bus_cpu][b] = !addr[7];
          else         pend_sh_d[(bw-1)*32+b] = !addr[7];
        end
      end
      if (addr[11:10] == R_PRIO && lw < NIRQ/4)
        for (int l = 0; l < 4; l++) prio_d[4*lw+l] = wdata[8*l +: PW];
      if (addr[11:10] == R_TGT && lw >= 8 && lw < NIRQ/4)
        for (int l = 0; l < 4; l++) tgt_d[4*lw+l-32] = wdata[8*l +: NCPU];
      if (addr[11:8] == R_CFG && cw < NIRQ/16)
        for (int l = 0; l < 16; l++) cfg_d[16*cw+l] = wdata[2*l +: 2];
      if (addr == A_SGI)
        for (int c = 0; c < NCPU; c++)
          if (wdata[16+c]) pend_pv_d[c][{1'b0, wdata[3:0]}] = 1'b1;
    end
    // edge-mode lines latch on a rising edge
    for (int i = 0; i < NSH; i++)
      if (cfg_q[32+i][1] && shared_irq[i] && !line_q[i]) pend_sh_d[i] = 1'b1;
  end

  // read mux
  always_comb begin
    rdata_d = '0;
    if (rd_en) begin
      if (addr == A_CTRL) rdata_d[0] = ctrl_q;
      if (addr == A_INFO) rdata_d[4:0] = 5'(NW - 1);
      if (addr[11:8] == R_EN && bw < NW)
        rdata_d = (bw == 0) ? en_pv_q[bus_cpu] : en_sh_q[(bw-1)*32 +: 32];
      if (addr[11:8] == R_PEND && bw < NW)
        rdata_d = (bw == 0) ? pend_pv_q[bus_cpu] : pend_sh_eff[(bw-1)*32 +: 32];
      if (addr[11:10] == R_PRIO && lw < NIRQ/4)
        for (int l = 0; l < 4; l++) rdata_d[8*l +: PW] = prio_q[4*lw+l];
      if (addr[11:10] == R_TGT && lw >= 8 && lw < NIRQ/4)
        for (int l = 0; l < 4; l++) rdata_d[8*l +: NCPU] = tgt_q[4*lw+l-32];
      if (addr[11:8] == R_CFG && cw < NIRQ/16)
        for (int l = 0; l < 16; l++) rdata_d[2*l +: 2] = cfg_q[16*cw+l];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 1'b0; en_pv_q <= '0; en_sh_q <= '0; prio_q <= '0;
      tgt_q <= '0; cfg_q <= '0; pend_pv_q <= '0; pend_sh_q <= '0;
      line_q <= '0; rdata_q <= '0;
    end else begin
      if (wr_en) begin
        ctrl_q <= ctrl_d; en_pv_q <= en_pv_d; en_sh_q <= en_sh_d;
        prio_q <= prio_d; tgt_q <= tgt_d; cfg_q <= cfg_d;
      end
      pend_pv_q <= pend_pv_d;
      pend_sh_q <= pend_sh_d;
      line_q    <= shared_irq;
      rdata_q   <= rdata_d;
    end
  end

  assign rdata = rdata_q;
  assign fwd_en = ctrl_q;
  assign en_pv = en_pv_q;
  assign pend_pv = pend_pv_q;
  assign en_sh = en_sh_q;
  assign tgt = tgt_q;
  assign prio = prio_q;
endmodule

// File: rtl/irqd_pick.sv
module irqd_pick #(
  parameter int NIRQ = 64,
  parameter int PW   = 8,
  parameter int IW   = 6
) (
  input  logic [NIRQ-1:0]          cand,
  input  logic [NIRQ-1:0][PW-1:0]  prio,
  output logic                     valid,
  output logic [IW-1:0]            id,
  output logic [PW-1:0]            pri
);
  // ascending scan, strict compare: equal priority keeps the lower ID
  always_comb begin
    valid = 1'b0;
    id    = '0;
    pri   = '0;
    for (int i = 0; i < NIRQ; i++) begin
      if (cand[i] && (!valid || prio[i] < pri)) begin
        valid = 1'b1;
        id    = IW'(i);
        pri   = prio[i];
      end
    end
  end
endmodule

// File: rtl/irqd_top.sv
module irqd_top #(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 4,
  parameter int PRIO_W  = 8,
  localparam int NSH = NUM_IRQ - 32,
  localparam int IW  = $clog2(NUM_IRQ),
  localparam int CW  = $clog2(NUM_CPU)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CW-1:0]           bus_cpu,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [11:0]             addr,
  input  logic [31:0]             wdata,
  output logic [31:0]             rdata,
  input  logic [NSH-1:0]          shared_irq,
  output logic [NUM_CPU-1:0]      cpu_irq,
  output logic [NUM_CPU*IW-1:0]   cpu_irq_id,
  output logic [NUM_CPU*PRIO_W-1:0] cpu_irq_prio
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic                           fwd_en;
  logic [NUM_CPU-1:0][31:0]       en_pv, pend_pv;
  logic [NSH-1:0]                 en_sh, pend_sh_eff;
  logic [NSH-1:0][NUM_CPU-1:0]    tgt;
  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio;

  irqd_regs #(.NIRQ(NUM_IRQ), .NCPU(NUM_CPU), .PW(PRIO_W), .CW(CW)) regs_i (
    .clk(clk), .rst_n(rst_sync_n), .bus_cpu(bus_cpu), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .shared_irq(shared_irq),
    .rdata(rdata), .fwd_en(fwd_en), .en_pv(en_pv), .pend_pv(pend_pv),
    .en_sh(en_sh), .pend_sh_eff(pend_sh_eff), .tgt(tgt), .prio(prio)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_IRQ-1:0] cand;
    always_comb begin
      for (int i = 0; i < 32; i++)
        cand[i] = fwd_en & en_pv[c][i] & pend_pv[c][i];
      for (int i = 0; i < NSH; i++)
        cand[32+i] = fwd_en & en_sh[i] & pend_sh_eff[i] & tgt[i][c];
    end
    irqd_pick #(.NIRQ(NUM_IRQ), .PW(PRIO_W), .IW(IW)) pick_i (
      .cand(cand), .prio(prio), .valid(cpu_irq[c]),
      .id(cpu_irq_id[c*IW +: IW]), .pri(cpu_irq_prio[c*PRIO_W +: PRIO_W])
    );
  end
endmodule

// File: rtl/irqd_top_chk.sv
module irqd_top_chk
  import irqd_pkg::*;
#(
  parameter int NIRQ = 64,
  parameter int NCPU = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic [11:0]           addr,
  input logic [31:0]           wdata,
  input logic [31:0]           rdata,
  input logic                  fwd_en,
  input logic [NCPU-1:0]       cpu_irq,
  input logic [NIRQ-33:0]      en_sh,
  input logic [NCPU-1:0][31:0] pend_pv
);
  // R4: no request leaves while forwarding is off
  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_en |-> cpu_irq == '0);

  // R3: all-ones to the first shared set word enables IDs 32..63
  p_enset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 12'h104 && wdata == 32'hFFFF_FFFF) |=> (&en_sh[31:0]));

  // R3: all-ones to the first shared clear word disables IDs 32..63
  p_enclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 12'h184 && wdata == 32'hFFFF_FFFF) |=> (en_sh[31:0] == '0));

  // R9: a soft interrupt aimed at processor 0 lands in its banked copy
  p_sgi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SGI && wdata[16]) |=> pend_pv[0][{1'b0, $past(wdata[3:0])}]);

  // R12: read data is zero unless a read was issued the cycle before
  p_rdidle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> rdata == '0);
endmodule

bind irqd_top irqd_top_chk #(.NIRQ(NUM_IRQ), .NCPU(NUM_CPU)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .fwd_en(fwd_en), .cpu_irq(cpu_irq),
  .en_sh(en_sh), .pend_pv(pend_pv)
);

// File: tb/irqd_top_tb_top.sv
module irqd_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  bus_cpu;
  logic        wr_en, rd_en;
  logic [11:0] addr;
  logic [31:0] wdata, rdata;
  logic [31:0] shared_irq;
  logic [3:0]  cpu_irq;
  logic [23:0] cpu_irq_id;
  logic [31:0] cpu_irq_prio;

  always #4 clk = ~clk;  // 125 MHz

  irqd_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_cpu(bus_cpu), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .shared_irq(shared_irq),
    .cpu_irq(cpu_irq), .cpu_irq_id(cpu_irq_id), .cpu_irq_prio(cpu_irq_prio)
  );

  // scoreboard: kind 0 = rdata, kind 1 = {valid, id} of one processor
  typedef struct {
    int          kind;
    int          cpu;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        if (it.kind == 0) act = rdata;
        else act = (cpu_irq[it.cpu] ? 32'h100 : 32'h0) | 32'(cpu_irq_id[it.cpu*6 +: 6]);
        n_chk++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] c, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_cpu = c; addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic rd_exp(input logic [1:0] c, input logic [11:0] a,
                        input logic [31:0] e, input string t);
    item_t it;
    @(negedge clk);
    bus_cpu = c; addr = a; rd_en = 1'b1;
    it.kind = 0; it.cpu = 0; it.exp = e; it.tag = t;
    q.push_back(it);
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic idle_exp(input string t);
    item_t it;
    @(negedge clk);
    it.kind = 0; it.cpu = 0; it.exp = 32'h0; it.tag = t;
    q.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic irq_exp(input int c, input bit v, input int id, input string t);
    item_t it;
    @(negedge clk);
    it.kind = 1; it.cpu = c; it.exp = v ? (32'h100 | 32'(id)) : 32'h0; it.tag = t;
    q.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic line(input int i, input bit v);
    @(negedge clk);
    shared_irq[i] = v;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_cpu = '0; wr_en = 1'b0; rd_en = 1'b0;
    addr = '0; wdata = '0; shared_irq = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd_exp(0, 12'h000, 32'h0, "R1 ctrl after reset");
    rd_exp(0, 12'h104, 32'h0, "R1 enables after reset");
    rd_exp(0, 12'h420, 32'h0, "R1 priority after reset");
    rd_exp(0, 12'h820, 32'h0, "R1 target after reset");
    for (int c = 0; c < 4; c++) irq_exp(c, 0, 0, "R1 no request after reset");
    // R2
    rd_exp(0, 12'h004, 32'h1, "R2 line count field");
    // R3 set/clear banks
    wr(0, 12'h104, 32'h5);
    rd_exp(0, 12'h104, 32'h5, "R3 set bank");
    wr(0, 12'h104, 32'h2);
    rd_exp(0, 12'h104, 32'h7, "R3 zero bits keep state");
    wr(0, 12'h184, 32'h4);
    rd_exp(0, 12'h184, 32'h3, "R3 clear bank");
    idle_exp("R12 rdata zero after read");
    // priorities and targets for IDs 32..35
    wr(0, 12'h420, 32'h1020_3040);
    rd_exp(0, 12'h420, 32'h1020_3040, "R5 priority lanes");
    wr(0, 12'h820, 32'h0201_0301);
    rd_exp(0, 12'h820, 32'h0201_0301, "R7 target lanes");
    // R4 gate
    line(0, 1);
    irq_exp(0, 0, 0, "R4 forwarding off");
    wr(0, 12'h000, 32'h1);
    irq_exp(0, 1, 32, "R4 forwarding on, R10 level line");
    // R5/R7
    line(1, 1);
    irq_exp(0, 1, 33, "R5 lower value wins");
    irq_exp(1, 1, 33, "R7 routed to cpu1");
    irq_exp(2, 0, 0, "R7 not routed to cpu2");
    irq_exp(3, 0, 0, "R7 not routed to cpu3");
    // R6 tie
    wr(0, 12'h420, 32'h1020_3030);
    irq_exp(0, 1, 32, "R6 tie lower id");
    irq_exp(1, 1, 33, "R7 cpu1 only sees id33");
    // R10 level release
    line(0, 0);
    irq_exp(0, 1, 33, "R10 level drop id32");
    line(1, 0);
    irq_exp(0, 0, 0, "R10 level drop id33");
    // R10/R11 edge mode on id34
    wr(0, 12'hC08, 32'h20);
    rd_exp(0, 12'hC08, 32'h20, "R11 trigger field readback");
    wr(0, 12'h104, 32'h4);
    line(2, 1);
    line(2, 0);
    irq_exp(0, 1, 34, "R10 edge latched after pulse");
    rd_exp(0, 12'h284, 32'h4, "R10 pending readback");
    wr(0, 12'h284, 32'h4);
    irq_exp(0, 0, 0, "R10 pending cleared");
    // R8 banking
    wr(1, 12'h100, 32'h1);
    wr(1, 12'h200, 32'h1);
    irq_exp(1, 1, 0, "R8 cpu1 private id0");
    irq_exp(0, 0, 0, "R8 cpu0 unaffected");
    rd_exp(0, 12'h100, 32'h0, "R8 cpu0 bank");
    rd_exp(1, 12'h100, 32'h1, "R8 cpu1 bank");
    // R9 soft interrupt
    wr(0, 12'h100, 32'h20);
    wr(2, 12'h100, 32'h20);
    wr(0, 12'hF00, 32'h0005_0005);
    irq_exp(0, 1, 5, "R9 cpu0 soft id5");
    irq_exp(2, 1, 5, "R9 cpu2 soft id5");
    irq_exp(3, 0, 0, "R9 cpu3 not named");
    irq_exp(1, 1, 0, "R9 cpu1 not named keeps id0");
    rd_exp(3, 12'h200, 32'h0, "R9 cpu3 pending untouched");
    rd_exp(2, 12'h200, 32'h20, "R9 cpu2 pending set");

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule